// File: doc/BRIEF.md
# Retimer Output Routing Controller

This block decides, on every clock cycle, which signal source feeds each of the two serial output lanes of a retimer: mute, raw equalized data, retimed data, the full-rate VCO clock, the VCO clock divided by 40, or a 10 MHz reference clock. The choice depends on the live CDR lock flag, on whether the locked rate is above 3G, and on a layered set of controls. A two-bit common code, taken from a configuration pin or from a register field that overrides the pin, steers both lanes together. An individual mode bypasses the common code and gives each lane its own three-bit select field.

The per-lane choices leave the block as registered one-hot select vectors, so that the downstream output multiplexers switch cleanly on a clock edge. Alongside them the block provides an OUT1 polarity-invert flag, a flag per lane for an invalid individual select code, and a readback of the select code actually applied to each lane, written in that lane's own individual-select encoding.

Top module: `out_route_ctrl`

## Requirements
- R1: Each lane select is a 6-bit one-hot vector with bit 0 mute, bit 1 raw data, bit 2 retimed data, bit 3 full-rate VCO clock, bit 4 VCO/40 clock and bit 5 10 MHz clock. While reset is high, both lanes are muted, the readbacks are 000 (lane 0) and 111 (lane 1), and the invert and invalid flags are 0.
- R2: Outside individual mode, the common code comes from `pin_common` when `pin_ovr_en` is 0 and from `reg_common` when it is 1.
- R3: Common code 00 mutes both lanes. Common code 11 selects raw data on both lanes, locked or not.
- R4: Common code 10 selects retimed data on both lanes while `cdr_locked` is 1, and raw data on both while it is 0.
- R5: Under common code 01 while locked, lane 0 carries retimed data and lane 1 carries the full-rate VCO clock if `rate_above_3g` is 0, or the VCO/40 clock if it is 1. While unlocked, lane 0 carries raw data and lane 1 is muted.
- R6: In individual mode (`indiv_en` = 1), `reg_sel0` picks lane 0 as follows: 000 mute, 001 10 MHz clock, 010 raw, 100 retimed. Lane 0 never carries a VCO clock.
- R7: In individual mode, `reg_sel1` picks lane 1 as follows: 000 raw, 001 retimed, 010 full-rate VCO clock, 111 mute. Code 101 gives the 10 MHz clock when `div_clk_pick` is 0 and the VCO/40 clock when it is 1.
- R8: In individual mode, a select code not listed for its lane mutes that lane and raises its invalid flag. Outside individual mode, both invalid flags are 0.
- R9: `sel0_readback` and `sel1_readback` give the applied source of each lane in the encoding of R6 and R7 (lane 1 divided or 10 MHz clock both read 101), in every mode.
- R10: `lane1_invert` follows `inv_out1_cfg`. There is no inversion control for lane 0, and the invert setting has no effect on either lane's source.
- R11: All outputs are registered. A change on any input, including the lock flag, appears at the outputs after exactly one rising clock edge and never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cdr_locked | input | 1 | CDR lock flag |
| rate_above_3g | input | 1 | Locked rate is above 3G |
| pin_common | input | 2 | Common code from the configuration pin |
| pin_ovr_en | input | 1 | Use the register common code instead of the pin |
| reg_common | input | 2 | Common code register field |
| indiv_en | input | 1 | Per-lane individual select mode |
| reg_sel0 | input | 3 | Individual select field for lane 0 |
| reg_sel1 | input | 3 | Individual select field for lane 1 |
| div_clk_pick | input | 1 | Lane 1 code 101: 0 = 10 MHz, 1 = VCO/40 |
| inv_out1_cfg | input | 1 | Invert lane 1 polarity |
| lane0_src | output | 6 | One-hot source select, lane 0 |
| lane1_src | output | 6 | One-hot source select, lane 1 |
| lane1_invert | output | 1 | Lane 1 polarity invert |
| sel0_readback | output | 3 | Applied lane 0 select code |
| sel1_readback | output | 3 | Applied lane 1 select code |
| sel0_invalid | output | 1 | Lane 0 individual code invalid |
| sel1_invalid | output | 1 | Lane 1 individual code invalid |

## Verification
The risky collision is a lock transition that lands on the same clock edge as a change in how the source is chosen: entering or leaving individual mode, or flipping the pin override. The bench changes `cdr_locked` together with `indiv_en` or `pin_ovr_en` in one cycle, and confirms that the outputs keep their previous values until the next edge. It then confirms that they show the source computed from the new mode and the new lock state together, with no intermediate value from either change alone. The same test is repeated with an invalid individual code, to show that muting wins whatever the lock state.

// File: rtl/out_route_pkg.sv
package out_route_pkg;

    localparam int SRC_W  = 6;
    localparam int CODE_W = 2;
    localparam int SEL_W  = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_MUTE      = 6'b000001,
        SRC_RAW       = 6'b000010,
        SRC_RETIMED   = 6'b000100,
        SRC_VCO_FULL  = 6'b001000,
        SRC_VCO_DIV40 = 6'b010000,
        SRC_REF10M    = 6'b100000
    } src_t;

    typedef enum logic [CODE_W-1:0] {
        CM_MUTE     = 2'b00,
        CM_DATA_CLK = 2'b01,
        CM_RETIME   = 2'b10,
        CM_RAW      = 2'b11
    } common_t;

    typedef struct packed {
        src_t src;
        logic invalid;
    } lane_pick_t;

    // Lane 0 individual encoding of an applied source
    function automatic logic [SEL_W-1:0] enc_lane0(input src_t s);
        case (s)
            SRC_REF10M:  return 3'b001;
            SRC_RAW:     return 3'b010;
            SRC_RETIMED: return 3'b100;
            default:     return 3'b000;
        endcase
    endfunction

    // Lane 1 individual encoding of an applied source
    function automatic logic [SEL_W-1:0] enc_lane1(input src_t s);
        case (s)
            SRC_RAW:       return 3'b000;
            SRC_RETIMED:   return 3'b001;
            SRC_VCO_FULL:  return 3'b010;
            SRC_VCO_DIV40: return 3'b101;
            SRC_REF10M:    return 3'b101;
            default:       return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/route_common_dec.sv
module route_common_dec
    import out_route_pkg::*;
(
    input  common_t code,
    input  logic    locked,
    input  logic    above_3g,
    output src_t    src0,
    output src_t    src1
);
    always_comb begin
        src0 = SRC_MUTE;
        src1 = SRC_MUTE;
        unique case (code)
            CM_MUTE: begin
                src0 = SRC_MUTE;
                src1 = SRC_MUTE;
            end
            CM_DATA_CLK: begin
                if (locked) begin
                    src0 = SRC_RETIMED;
                    src1 = above_3g ? SRC_VCO_DIV40 : SRC_VCO_FULL;
                end else begin
                    src0 = SRC_RAW;
                    src1 = SRC_MUTE;
                end
            end
            CM_RETIME: begin
                src0 = locked ? SRC_RETIMED : SRC_RAW;
                src1 = locked ? SRC_RETIMED : SRC_RAW;
            end
            CM_RAW: begin
                src0 = SRC_RAW;
                src1 = SRC_RAW;
            end
        endcase
    end
endmodule

// File: rtl/route_lane0_dec.sv
module route_lane0_dec
    import out_route_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output lane_pick_t       pick
);
    always_comb begin
        pick.invalid = 1'b0;
        case (sel)
            3'b000:  pick.src = SRC_MUTE;
            3'b001:  pick.src = SRC_REF10M;
            3'b010:  pick.src = SRC_RAW;
            3'b100:  pick.src = SRC_RETIMED;
            default: begin
                pick.src     = SRC_MUTE;
                pick.invalid = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/route_lane1_dec.sv
module route_lane1_dec
    import out_route_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             div_pick,
    output lane_pick_t       pick
);
    always_comb begin
        pick.invalid = 1'b0;
        case (sel)
            3'b000:  pick.src = SRC_RAW;
            3'b001:  pick.src = SRC_RETIMED;
            3'b010:  pick.src = SRC_VCO_FULL;
            3'b101:  pick.src = div_pick ? SRC_VCO_DIV40 : SRC_REF10M;
            3'b111:  pick.src = SRC_MUTE;
            default: begin
                pick.src     = SRC_MUTE;
                pick.invalid = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/out_route_ctrl.sv
module out_route_ctrl
    import out_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cdr_locked,
    input  logic              rate_above_3g,
    input  logic [CODE_W-1:0] pin_common,
    input  logic              pin_ovr_en,
    input  logic [CODE_W-1:0] reg_common,
    input  logic              indiv_en,
    input  logic [SEL_W-1:0]  reg_sel0,
    input  logic [SEL_W-1:0]  reg_sel1,
    input  logic              div_clk_pick,
    input  logic              inv_out1_cfg,
    output logic [SRC_W-1:0]  lane0_src,
    output logic [SRC_W-1:0]  lane1_src,
    output logic              lane1_invert,
    output logic [SEL_W-1:0]  sel0_readback,
    output logic [SEL_W-1:0]  sel1_readback,
    output logic              sel0_invalid,
    output logic              sel1_invalid
);
    common_t    eff_code;
    src_t       cm_src0, cm_src1;
    lane_pick_t ind0, ind1;
    lane_pick_t nxt0, nxt1;

    assign eff_code = common_t'(pin_ovr_en ? reg_common : pin_common);

    route_common_dec u_common (
        .code     (eff_code),
        .locked   (cdr_locked),
        .above_3g (rate_above_3g),
        .src0     (cm_src0),
        .src1     (cm_src1)
    );

    route_lane0_dec u_lane0 (
        .sel  (reg_sel0),
        .pick (ind0)
    );

    route_lane1_dec u_lane1 (
        .sel      (reg_sel1),
        .div_pick (div_clk_pick),
        .pick     (ind1)
    );

    always_comb begin
        if (indiv_en) begin
            nxt0 = ind0;
            nxt1 = ind1;
        end else begin
            nxt0 = '{src: cm_src0, invalid: 1'b0};
            nxt1 = '{src: cm_src1, invalid: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane0_src     <= SRC_MUTE;
            lane1_src     <= SRC_MUTE;
            lane1_invert  <= 1'b0;
            sel0_readback <= 3'b000;
            sel1_readback <= 3'b111;
            sel0_invalid  <= 1'b0;
            sel1_invalid  <= 1'b0;
        end else begin
            lane0_src     <= nxt0.src;
            lane1_src     <= nxt1.src;
            lane1_invert  <= inv_out1_cfg;
            sel0_readback <= enc_lane0(nxt0.src);
            sel1_readback <= enc_lane1(nxt1.src);
            sel0_invalid  <= nxt0.invalid;
            sel1_invalid  <= nxt1.invalid;
        end
    end

    AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(lane0_src) && $onehot(lane1_src)); // R1
    AST_OUT0_NO_VCO: assert property (@(posedge clk) disable iff (rst)
        !lane0_src[3] && !lane0_src[4]); // R6
    AST_INVALID_MUTES: assert property (@(posedge clk) disable iff (rst)
        (sel0_invalid |-> lane0_src == SRC_MUTE) and (sel1_invalid |-> lane1_src == SRC_MUTE)); // R8
    AST_COMMON_NO_INVALID: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(indiv_en)) |-> (!sel0_invalid && !sel1_invalid)); // R8
    AST_RETIME_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(indiv_en) && $past(eff_code) == CM_RETIME)
        |-> (lane0_src == ($past(cdr_locked) ? SRC_RETIMED : SRC_RAW))); // R4
    AST_INVERT_DELAY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> lane1_invert == $past(inv_out1_cfg)); // R10

endmodule

// File: tb/out_route_ctrl_tb_top.sv
module out_route_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cdr_locked = 1'b0, rate_above_3g = 1'b0;
    logic [1:0] pin_common = 2'b10, reg_common = 2'b00;
    logic       pin_ovr_en = 1'b0, indiv_en = 1'b0;
    logic [2:0] reg_sel0 = 3'b000, reg_sel1 = 3'b000;
    logic       div_clk_pick = 1'b0, inv_out1_cfg = 1'b0;
    logic [5:0] lane0_src, lane1_src;
    logic       lane1_invert, sel0_invalid, sel1_invalid;
    logic [2:0] sel0_readback, sel1_readback;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [5:0] MUTE = 6'b000001, RAW = 6'b000010, RET = 6'b000100,
                           VFULL = 6'b001000, VDIV = 6'b010000, REF = 6'b100000;

    always #2.5 clk = ~clk;

    out_route_ctrl dut_i (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model from the requirements
    function automatic logic [5:0] m_lane0();
        logic [1:0] c;
        if (indiv_en) begin
            if (reg_sel0 == 3'b001) return REF;
            if (reg_sel0 == 3'b010) return RAW;
            if (reg_sel0 == 3'b100) return RET;
            return MUTE;
        end
        c = pin_ovr_en ? reg_common : pin_common;
        if (c == 2'b00) return MUTE;
        if (c == 2'b11) return RAW;
        return cdr_locked ? RET : RAW;
    endfunction

    function automatic logic [5:0] m_lane1();
        logic [1:0] c;
        if (indiv_en) begin
            if (reg_sel1 == 3'b000) return RAW;
            if (reg_sel1 == 3'b001) return RET;
            if (reg_sel1 == 3'b010) return VFULL;
            if (reg_sel1 == 3'b101) return div_clk_pick ? VDIV : REF;
            return MUTE;
        end
        c = pin_ovr_en ? reg_common : pin_common;
        if (c == 2'b00) return MUTE;
        if (c == 2'b11) return RAW;
        if (c == 2'b10) return cdr_locked ? RET : RAW;
        if (!cdr_locked) return MUTE;
        return rate_above_3g ? VDIV : VFULL;
    endfunction

    function automatic logic [2:0] m_rb0(input logic [5:0] s);
        return (s == REF) ? 3'b001 : (s == RAW) ? 3'b010 : (s == RET) ? 3'b100 : 3'b000;
    endfunction

    function automatic logic [2:0] m_rb1(input logic [5:0] s);
        return (s == RAW) ? 3'b000 : (s == RET) ? 3'b001 : (s == VFULL) ? 3'b010 :
               (s == VDIV || s == REF) ? 3'b101 : 3'b111;
    endfunction

    function automatic logic m_inv0();
        return indiv_en && !(reg_sel0 inside {3'b000, 3'b001, 3'b010, 3'b100});
    endfunction

    function automatic logic m_inv1();
        return indiv_en && !(reg_sel1 inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b111});
    endfunction

    // Expected values captured before the edge, compared after it
    logic [5:0] e0, e1;
    logic       ei0, ei1, einv;

    task automatic capture();
        e0 = m_lane0(); e1 = m_lane1();
        ei0 = m_inv0(); ei1 = m_inv1(); einv = inv_out1_cfg;
    endtask

    task automatic step_check(input string req);
        capture();
        @(posedge clk); #1;
        chk(req, "lane0_src", lane0_src, e0);
        chk(req, "lane1_src", lane1_src, e1);
        chk("R9", "sel0_readback", sel0_readback, m_rb0(e0));
        chk("R9", "sel1_readback", sel1_readback, m_rb1(e1));
        chk("R8", "sel0_invalid", sel0_invalid, ei0);
        chk("R8", "sel1_invalid", sel1_invalid, ei1);
        chk("R10", "lane1_invert", lane1_invert, einv);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "reset lane0", lane0_src, MUTE);
        chk("R1", "reset lane1", lane1_src, MUTE);
        chk("R1", "reset rb0", sel0_readback, 3'b000);
        chk("R1", "reset rb1", sel1_readback, 3'b111);
        chk("R1", "reset flags", {lane1_invert, sel0_invalid, sel1_invalid}, 0);
        rst = 1'b0;
    endtask

    task automatic t_common_source();
        for (int c = 0; c < 4; c++) begin
            pin_common = 2'(c); reg_common = 2'(3 - c); pin_ovr_en = 1'b0;
            cdr_locked = 1'b1; step_check("R2");
            pin_ovr_en = 1'b1; step_check("R2");
        end
        pin_ovr_en = 1'b0;
    endtask

    task automatic t_mute_raw();
        for (int l = 0; l < 2; l++) begin
            cdr_locked = l[0];
            pin_common = 2'b00; step_check("R3");
            pin_common = 2'b11; step_check("R3");
        end
    endtask

    task automatic t_retime();
        pin_common = 2'b10;
        cdr_locked = 1'b1; step_check("R4");
        cdr_locked = 1'b0; step_check("R4");
    endtask

    task automatic t_data_clk();
        pin_common = 2'b01;
        for (int k = 0; k < 4; k++) begin
            cdr_locked = k[1]; rate_above_3g = k[0];
            step_check("R5");
        end
    endtask

    task automatic t_indiv0();
        indiv_en = 1'b1; reg_sel1 = 3'b111;
        for (int s = 0; s < 8; s++) begin
            reg_sel0 = 3'(s);
            step_check("R6");
        end
    endtask

    task automatic t_indiv1();
        indiv_en = 1'b1; reg_sel0 = 3'b010;
        for (int s = 0; s < 8; s++) begin
            reg_sel1 = 3'(s);
            div_clk_pick = 1'b0; step_check("R7");
            div_clk_pick = 1'b1; step_check("R7");
        end
        indiv_en = 1'b0;
    endtask

    task automatic t_polarity();
        pin_common = 2'b10; cdr_locked = 1'b1;
        inv_out1_cfg = 1'b1; step_check("R10");
        chk("R10", "lane0 unaffected by invert", lane0_src, RET);
        inv_out1_cfg = 1'b0; step_check("R10");
    endtask

    task automatic t_latency();
        pin_common = 2'b10; cdr_locked = 1'b1; step_check("R11");
        cdr_locked = 1'b0; #1;
        chk("R11", "lane0 held before edge", lane0_src, RET);
        chk("R11", "lane1 held before edge", lane1_src, RET);
        step_check("R11");
    endtask

    task automatic t_coincide();
        // Lock rises in the same cycle as the switch into individual mode
        pin_common = 2'b01; cdr_locked = 1'b0; indiv_en = 1'b0; step_check("R11");
        cdr_locked = 1'b1; indiv_en = 1'b1; reg_sel0 = 3'b100; reg_sel1 = 3'b011; #1;
        chk("R11", "lane0 before coincident edge", lane0_src, RAW);
        step_check("R8");
        // Leave individual mode and flip the override while lock drops
        indiv_en = 1'b0; cdr_locked = 1'b0; pin_ovr_en = 1'b1; reg_common = 2'b01;
        step_check("R2");
        cdr_locked = 1'b1; rate_above_3g = 1'b1; pin_ovr_en = 1'b0; pin_common = 2'b10;
        step_check("R4");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_common_source();
        t_mute_raw();
        t_retime();
        t_data_clk();
        t_indiv0();
        t_indiv1();
        t_polarity();
        t_latency();
        t_coincide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule